// File: doc/BRIEF.md
# Load Data Formatter with Zero Test

This block sits at the end of a load or integer pipeline, just before the register write. It takes a 64-bit doubleword and produces the value to be written. It selects the bytes of the access at any byte offset and can reverse their order. It keeps 1, 2, 4 or 8 bytes and fills the bytes above them with zeros or with copies of the sign bit. When an access crosses a doubleword boundary, the part taken from the first doubleword is held in a register and joined with the bytes of the following doubleword. Sign-extension operations use the same path: offset zero, the wanted length, and the sign-extend flag set.

Each output byte has its own any-of-eight byte selector, so rotation and reversal happen in one step. A per-byte stage then trims, extends and splices the bytes. When the record flag is set, the final value is compared with zero to give a 4-bit condition field. Results are registered and appear one cycle after the beat that completes the access.

Memory bytes are little-endian. Byte `k` of an access is memory byte `offset + k`. Bytes at positions 8 and above come from the second doubleword, at byte index `offset + k - 8`.

Top module: `ldfmt_top`

## Requirements
- R1: During and after reset, `out_valid`, `out_data` and `out_cr` are all zero until the first result is produced.
- R2: A first beat (`in_valid`=1, `in_second`=0) with `in_offset` + L not above 8 gives `out_valid`=1 on the next cycle. `out_data` byte k equals input byte `in_offset`+k for every k below L, and the bytes above L are zero when `in_sext`=0. The length code `in_size` is 0, 1, 2 or 3, meaning L = 1, 2, 4 or 8 bytes.
- R3: With `in_rev`=1, result byte k holds access byte L-1-k.
- R4: With `in_sext`=1, every result byte at position L or above is 0xFF if bit 7 of result byte L-1 (taken after any reversal) is one, and 0x00 otherwise. An 8-byte access is unchanged by the flag.
- R5: A first beat with `in_offset` + L above 8 produces no output. The next beat with `in_second`=1 supplies the remaining bytes, and the spliced result appears one cycle after that beat. Offset, length, reversal, sign, record and summary-overflow values all come from the first beat; those inputs on the second beat are ignored.
- R6: A beat with `in_second`=1 and no access waiting is ignored: no `out_valid` follows it.
- R7: A first beat that arrives while an access is waiting for its second beat discards the waiting access; only the new access produces a result.
- R8: With the record flag set, `out_cr` is {LT, GT, EQ, SO} from bit 3 down to bit 0. LT is `out_data` bit 63, GT means the value is non-negative and non-zero, EQ means the value is zero, and bit 0 copies `in_so` from the first beat. With the record flag clear, `out_cr` is 0000.
- R9: A cycle with `in_valid`=0 is followed by `out_valid`=0.
- R10: Accesses presented back to back, one beat per cycle, each yield one result, in order, with no lost or extra results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_data | input | 64 | Doubleword of this beat |
| in_offset | input | 3 | Byte offset of the access (first beat) |
| in_size | input | 2 | Length code: 0=1, 1=2, 2=4, 3=8 bytes |
| in_rev | input | 1 | Reverse byte order |
| in_sext | input | 1 | Sign-extend above the length |
| in_second | input | 1 | Beat is the second doubleword of a spanning access |
| in_rc | input | 1 | Record flag: produce the condition field |
| in_so | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Formatted result |
| out_cr | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench goes after offsets where the access ends exactly on the doubleword boundary or one byte past it. A design with an off-by-one span test there would either wait for a second beat that never comes or splice in wrong bytes. Reversed spanning loads check that the splice choice follows the memory position and not the output position; getting this wrong mixes bytes of the two doublewords. Sign-fill cases use a negative top byte after reversal, orphan second beats, restarts while an access is waiting, and zero, negative and positive values for the condition field. A swapped LT/GT bit or a summary-overflow bit sampled on the wrong beat shows up as a bad condition field.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    // bit positions inside the condition field
    localparam int unsigned CR_LT = 3;
    localparam int unsigned CR_GT = 2;
    localparam int unsigned CR_EQ = 1;
    localparam int unsigned CR_SO = 0;

    // number of bytes selected by a length code, clamped to the word size
    function automatic int unsigned byte_count(input int unsigned code, input int unsigned nb);
        int unsigned l;
        l = 32'd1 << code;
        return (l > nb) ? nb : l;
    endfunction

    // true when an access starting at off with length code runs past the word
    function automatic logic crosses(input int unsigned off, input int unsigned code,
                                     input int unsigned nb);
        return (off + byte_count(code, nb)) > nb;
    endfunction

endpackage

// File: rtl/ldfmt_byte_sel.sv
// One any-of-NB byte selector per output byte: rotation and reversal in one step.
// NB must be a power of two.
module ldfmt_byte_sel
    import ldfmt_pkg::*;
#(
    parameter  int unsigned NB   = 8,
    localparam int unsigned DW   = NB * 8,
    localparam int unsigned OFFW = $clog2(NB),
    localparam int unsigned SZW  = $clog2($clog2(NB) + 1)
) (
    input  logic [DW-1:0]   din,
    input  logic [OFFW-1:0] off,
    input  logic [SZW-1:0]  size,
    input  logic            rev,
    output logic [DW-1:0]   dout
);

    logic [7:0] in_b [NB];

    for (genvar j = 0; j < NB; j++) begin : g_byte
        logic [OFFW-1:0] sel;

        assign in_b[j] = din[j*8 +: 8];

        always_comb begin
            int unsigned len;
            int unsigned k;
            len = byte_count(32'(size), NB);
            // access byte feeding output byte j (wraps harmlessly above len)
            k   = rev ? ((len + NB - 1 - 32'(j)) % NB) : 32'(j);
            sel = OFFW'((32'(off) + k) % NB);
        end

        assign dout[j*8 +: 8] = in_b[sel];
    end

endmodule

// File: rtl/ldfmt_trim.sv
// Per-byte splice, trim and sign fill.
module ldfmt_trim
    import ldfmt_pkg::*;
#(
    parameter  int unsigned NB   = 8,
    localparam int unsigned DW   = NB * 8,
    localparam int unsigned OFFW = $clog2(NB),
    localparam int unsigned SZW  = $clog2($clog2(NB) + 1)
) (
    input  logic [DW-1:0]   cur,
    input  logic [DW-1:0]   prev,
    input  logic [OFFW-1:0] off,
    input  logic [SZW-1:0]  size,
    input  logic            rev,
    input  logic            sext,
    input  logic            use_prev,
    output logic [DW-1:0]   dout
);

    logic [7:0]      cur_b [NB];
    logic [7:0]      prv_b [NB];
    logic [7:0]      spl_b [NB];
    logic [OFFW-1:0] top_idx;
    logic            sign_bit;
    logic [7:0]      fill_b;

    for (genvar j = 0; j < NB; j++) begin : g_split
        assign cur_b[j] = cur[j*8 +: 8];
        assign prv_b[j] = prev[j*8 +: 8];

        // a byte comes from the held word when its memory position lies below the boundary
        always_comb begin
            int unsigned len;
            int unsigned k;
            logic        take_prev;
            len       = byte_count(32'(size), NB);
            k         = (32'(j) < len) ? (rev ? (len - 1 - 32'(j)) : 32'(j)) : 32'd0;
            take_prev = use_prev && (32'(j) < len) && ((32'(off) + k) < NB);
            spl_b[j]  = take_prev ? prv_b[j] : cur_b[j];
        end
    end

    always_comb begin
        top_idx  = OFFW'(byte_count(32'(size), NB) - 1);
        sign_bit = spl_b[top_idx][7];
        fill_b   = {8{sext & sign_bit}};
    end

    for (genvar j = 0; j < NB; j++) begin : g_out
        always_comb begin
            if (32'(j) < byte_count(32'(size), NB)) dout[j*8 +: 8] = spl_b[j];
            else                                    dout[j*8 +: 8] = fill_b;
        end
    end

endmodule

// File: rtl/ldfmt_cond.sv
// Signed compare of the formatted value against zero.
module ldfmt_cond
    import ldfmt_pkg::*;
#(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] val,
    input  logic          rc,
    input  logic          so,
    output logic [3:0]    cr
);

    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (val == '0);
        is_neg  = val[DW-1];
        cr      = 4'b0000;
        if (rc) begin
            cr[CR_LT] = is_neg;
            cr[CR_GT] = !is_neg && !is_zero;
            cr[CR_EQ] = is_zero;
            cr[CR_SO] = so;
        end
    end

endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
    import ldfmt_pkg::*;
#(
    parameter  int unsigned NB   = 8,
    localparam int unsigned DW   = NB * 8,
    localparam int unsigned OFFW = $clog2(NB),
    localparam int unsigned SZW  = $clog2($clog2(NB) + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    input  logic [OFFW-1:0] in_offset,
    input  logic [SZW-1:0]  in_size,
    input  logic            in_rev,
    input  logic            in_sext,
    input  logic            in_second,
    input  logic            in_rc,
    input  logic            in_so,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    output logic [3:0]      out_cr
);

    typedef struct packed {
        logic            pend;
        logic [DW-1:0]   part;
        logic [OFFW-1:0] off;
        logic [SZW-1:0]  size;
        logic            rev;
        logic            sext;
        logic            rc;
        logic            so;
        logic            ovalid;
        logic [DW-1:0]   odata;
        logic [3:0]      ocr;
    } state_t;

    state_t s_q, s_d;

    logic            first_beat;
    logic            finish_beat;
    logic            first_span;
    logic [OFFW-1:0] c_off;
    logic [SZW-1:0]  c_size;
    logic            c_rev, c_sext, c_rc, c_so;
    logic [DW-1:0]   rot;
    logic [DW-1:0]   fmt;
    logic [3:0]      cr_nx;

    // control source: held values while completing a spanning access
    always_comb begin
        first_beat  = in_valid && !in_second;
        finish_beat = in_valid && in_second && s_q.pend;
        first_span  = crosses(32'(in_offset), 32'(in_size), NB);
        c_off       = finish_beat ? s_q.off  : in_offset;
        c_size      = finish_beat ? s_q.size : in_size;
        c_rev       = finish_beat ? s_q.rev  : in_rev;
        c_sext      = finish_beat ? s_q.sext : in_sext;
        c_rc        = finish_beat ? s_q.rc   : in_rc;
        c_so        = finish_beat ? s_q.so   : in_so;
    end

    ldfmt_byte_sel #(.NB(NB)) u_sel (
        .din  (in_data),
        .off  (c_off),
        .size (c_size),
        .rev  (c_rev),
        .dout (rot)
    );

    ldfmt_trim #(.NB(NB)) u_trim (
        .cur      (rot),
        .prev     (s_q.part),
        .off      (c_off),
        .size     (c_size),
        .rev      (c_rev),
        .sext     (c_sext),
        .use_prev (finish_beat),
        .dout     (fmt)
    );

    ldfmt_cond #(.DW(DW)) u_cond (
        .val (fmt),
        .rc  (c_rc),
        .so  (c_so),
        .cr  (cr_nx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.ovalid = 1'b0;
        if (first_beat) begin
            if (first_span) begin
                s_d.pend = 1'b1;
                s_d.part = rot;
                s_d.off  = in_offset;
                s_d.size = in_size;
                s_d.rev  = in_rev;
                s_d.sext = in_sext;
                s_d.rc   = in_rc;
                s_d.so   = in_so;
            end else begin
                s_d.pend   = 1'b0;
                s_d.ovalid = 1'b1;
                s_d.odata  = fmt;
                s_d.ocr    = cr_nx;
            end
        end else if (finish_beat) begin
            s_d.pend   = 1'b0;
            s_d.ovalid = 1'b1;
            s_d.odata  = fmt;
            s_d.ocr    = cr_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ovalid;
    assign out_data  = s_q.odata;
    assign out_cr    = s_q.ocr;

    // R2: a beat that fits in one word completes on the next cycle
    a_r2_one_word_done: assert property (@(posedge clk) disable iff (!rst_n)
        (first_beat && !first_span) |=> out_valid);

    // R5: a crossing first beat yields nothing yet and leaves an access waiting
    a_r5_wait_second: assert property (@(posedge clk) disable iff (!rst_n)
        (first_beat && first_span) |=> (!out_valid && s_q.pend));

    // R6: an orphan second beat produces no result
    a_r6_orphan_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_second && !s_q.pend) |=> !out_valid);

    // R9: no input, no output
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: EQ only for a zero result, LT only for a negative one
    a_r8_eq_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cr[CR_EQ]) |-> (out_data == '0));

    a_r8_lt_means_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cr[CR_LT]) |-> out_data[DW-1]);

endmodule

// File: tb/ldfmt_top_test.sv
module ldfmt_top_test;

    typedef struct {
        logic [63:0] d;
        logic [3:0]  cr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_offset = '0;
    logic [1:0]  in_size = '0;
    logic        in_rev = 1'b0, in_sext = 1'b0, in_second = 1'b0, in_rc = 1'b0, in_so = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [3:0]  out_cr;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t q[$];
    logic [7:0] mem [16];

    always #5 clk = ~clk;

    ldfmt_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_offset(in_offset), .in_size(in_size), .in_rev(in_rev), .in_sext(in_sext),
        .in_second(in_second), .in_rc(in_rc), .in_so(in_so),
        .out_valid(out_valid), .out_data(out_data), .out_cr(out_cr)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            total++; bad++;
            $display("FAIL R10 watchdog expired: actual=hung expected=finished");
            finish_run();
        end
    end

    // expected value from the memory view of the access
    function automatic logic [63:0] model(input int off, input int code, input bit rev, input bit sext);
        logic [63:0] v;
        int          len;
        logic        sgn;
        v   = '0;
        len = 1 << code;
        for (int k = 0; k < len; k++) begin
            int pos;
            pos = rev ? (len - 1 - k) : k;
            v[pos*8 +: 8] = mem[off + k];
        end
        sgn = v[(len-1)*8 + 7];
        for (int b = len; b < 8; b++) v[b*8 +: 8] = (sext && sgn) ? 8'hFF : 8'h00;
        return v;
    endfunction

    function automatic logic [3:0] cr_model(input logic [63:0] v, input bit rc, input bit so);
        if (!rc) return 4'b0000;
        return {v[63], (!v[63] && v != 0), (v == 0), so};
    endfunction

    function automatic logic [63:0] word(input int base);
        logic [63:0] w;
        for (int b = 0; b < 8; b++) w[b*8 +: 8] = mem[base + b];
        return w;
    endfunction

    task automatic beat(input bit sec, input logic [63:0] d, input int off, input int code,
                        input bit rev, input bit sext, input bit rc, input bit so);
        @(posedge clk); #1;
        in_valid = 1'b1; in_second = sec; in_data = d;
        in_offset = 3'(off); in_size = 2'(code);
        in_rev = rev; in_sext = sext; in_rc = rc; in_so = so;
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        in_valid = 1'b0; in_second = 1'b0;
        repeat (n - 1) @(posedge clk);
    endtask

    // push the expected result, then drive one or two beats
    task automatic do_access(input int off, input int code, input bit rev, input bit sext,
                             input bit rc, input bit so, input string tag);
        exp_t e;
        e.d   = model(off, code, rev, sext);
        e.cr  = cr_model(e.d, rc, so);
        e.tag = tag;
        q.push_back(e);
        beat(1'b0, word(0), off, code, rev, sext, rc, so);
        if (off + (1 << code) > 8) begin
            // R5: scrambled controls on the second beat must be ignored
            beat(1'b1, word(8), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
    endtask

    task automatic fill_rand();
        for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
    endtask

    task automatic fill_const(input logic [7:0] v);
        for (int i = 0; i < 16; i++) mem[i] = v;
    endtask

    // monitor: compare every produced result with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            exp_t e;
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL R6 R7 R9 unexpected result: actual=%h cr=%b expected=none", out_data, out_cr);
            end else begin
                e = q.pop_front();
                if (out_data !== e.d || out_cr !== e.cr) begin
                    bad++;
                    $display("FAIL %s: actual=%h cr=%b expected=%h cr=%b", e.tag, out_data, out_cr, e.d, e.cr);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #4;
        // R1: reset state
        total++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_cr !== 4'b0) begin
            bad++;
            $display("FAIL R1 reset: actual=%b/%h/%b expected=0/0/0", out_valid, out_data, out_cr);
        end
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_cr !== 4'b0) begin
            bad++;
            $display("FAIL R1 after reset: actual=%b/%h/%b expected=0/0/0", out_valid, out_data, out_cr);
        end

        // R2: every size at every offset that fits
        for (int code = 0; code < 4; code++) begin
            for (int off = 0; off + (1 << code) <= 8; off++) begin
                fill_rand();
                do_access(off, code, 1'b0, 1'b0, 1'b1, 1'b0, "R2 aligned/in-word");
            end
        end
        idle(2);

        // R3: reversal in-word
        fill_rand();
        do_access(0, 3, 1'b1, 1'b0, 1'b0, 1'b0, "R3 reverse 8B");
        do_access(2, 2, 1'b1, 1'b0, 1'b0, 1'b0, "R3 reverse 4B");
        do_access(6, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 reverse 2B at edge");
        idle(2);

        // R4: sign fill, negative and positive top byte, and the extension-op form
        fill_const(8'h00); mem[3] = 8'h80; mem[2] = 8'h11;
        do_access(2, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R4 sext negative 2B");
        do_access(2, 1, 1'b1, 1'b1, 1'b1, 1'b0, "R4 sext after reverse positive");
        do_access(2, 1, 1'b0, 1'b0, 1'b1, 1'b0, "R4 no sext zero fill");
        fill_rand(); mem[3] = 8'hF0;
        do_access(0, 2, 1'b0, 1'b1, 1'b0, 1'b0, "R4 sext 4B extension op");
        do_access(0, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 sext 1B extension op");
        do_access(0, 3, 1'b0, 1'b1, 1'b0, 1'b0, "R4 sext 8B unchanged");
        idle(2);

        // R5: crossing accesses, including reversed and one byte past the edge
        fill_rand();
        do_access(7, 1, 1'b0, 1'b0, 1'b1, 1'b1, "R5 cross 2B off7");
        do_access(5, 3, 1'b0, 1'b0, 1'b1, 1'b0, "R5 cross 8B off5");
        do_access(6, 2, 1'b1, 1'b0, 1'b1, 1'b1, "R5 cross reversed 4B");
        do_access(1, 3, 1'b1, 1'b1, 1'b0, 1'b0, "R5 cross reversed 8B off1");
        mem[9] = 8'h9C;
        do_access(7, 2, 1'b0, 1'b1, 1'b1, 1'b0, "R5 cross sext 4B");
        idle(3);

        // R6: orphan second beat, then a normal access
        beat(1'b1, 64'hDEAD_BEEF_0123_4567, 0, 3, 1'b0, 1'b0, 1'b1, 1'b1);
        idle(3);
        fill_rand();
        do_access(0, 3, 1'b0, 1'b0, 1'b1, 1'b0, "R6 access after orphan beat");
        idle(2);

        // R7: crossing first beat abandoned by a new first beat
        fill_rand();
        beat(1'b0, word(0), 6, 3, 1'b0, 1'b0, 1'b1, 1'b0);
        do_access(1, 1, 1'b0, 1'b0, 1'b1, 1'b0, "R7 restart replaces waiting access");
        beat(1'b1, word(8), 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);  // now an orphan
        idle(3);

        // R8: condition field for zero, negative, positive, record off, so copy
        fill_const(8'h00);
        do_access(0, 3, 1'b0, 1'b0, 1'b1, 1'b0, "R8 zero gives EQ");
        do_access(3, 3, 1'b0, 1'b0, 1'b1, 1'b1, "R8 zero crossing gives EQ with SO");
        fill_const(8'hFF);
        do_access(0, 3, 1'b0, 1'b0, 1'b1, 1'b1, "R8 negative gives LT");
        fill_const(8'h7F);
        do_access(0, 3, 1'b0, 1'b0, 1'b1, 1'b0, "R8 positive gives GT");
        do_access(0, 3, 1'b0, 1'b0, 1'b0, 1'b1, "R8 record off gives zero field");
        fill_const(8'h80);
        do_access(4, 0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 zero-extended byte is positive");
        idle(2);

        // R10 (and R9 via idle gaps): back-to-back random stream
        for (int i = 0; i < 400; i++) begin
            int off, code;
            code = int'($urandom_range(0, 3));
            off  = int'($urandom_range(0, 7));
            if ($urandom_range(0, 7) == 0) fill_const(8'h00);
            else fill_rand();
            do_access(off, code, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      "R10 back-to-back stream");
            if ($urandom_range(0, 9) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(5);

        // R10: nothing left outstanding
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R10 missing results: actual=%0d outstanding expected=0", q.size());
        end
        finish_run();
    end

endmodule